// File: doc/BRIEF.md
# Assignable bandwidth counter bank

This block holds a bank of byte counters for memory traffic. Software points each counter at one traffic stream through a single 64-bit configuration register. A stream is named by a 12-bit source value and a 32-bit transaction-type mask. Each counter slot compares its source either with the event's monitoring ID or with its class-of-service ID; the slot's own select bit picks which. On every incoming event, each enabled slot that matches adds the event's byte count to its counter. The counter saturates at its maximum value.

Software can build up the register over several writes. The fields reach a slot only on a write that has the apply bit set. That write loads the slot addressed by the register's ID field and clears its counter. The count-enable bit in the same write decides whether the slot counts from then on. A slot stays assigned until software applies a new configuration to it. A separate combinational port returns any counter's value by slot index. While the feature-enable input is low, every register access is refused. A write that sets a reserved bit is also refused. A refused access raises a one-cycle fault and changes nothing.

Top module: `bw_counter_bank`

## Requirements
- R1: After reset, the register reads zero, every counter reads zero, no slot counts and the fault output is low.
- R2: A write accepted with feature-enable high replaces the staged register. While feature-enable is high, the register read data shows the staged value.
- R3: A read or write while feature-enable is low raises the fault output in the next cycle and changes no state. The register read data is zero while feature-enable is low.
- R4: A write with any of bits 61:53 or 46:44 set raises the fault output in the next cycle and is ignored.
- R5: A write with bit 63 set loads bits 52:48 (slot index), bit 47, bits 43:32 and bits 31:0 into that slot, and the slot's counter reads zero after that edge.
- R6: If a write has bit 63 set and bit 62 clear, the slot holds the new configuration but its counter does not move on matching events.
- R7: If a write has bit 63 set and bit 62 set, the slot adds the byte count of every matching event from the next edge on.
- R8: An event matches a slot only in two cases. If the slot's bit 47 is set, the event's class-of-service ID must equal the slot's source. If it is clear, the event's monitoring ID must equal the slot's source. In both cases the event's type bits ANDed with the slot's type mask must be nonzero.
- R9: One event is added to every enabled slot it matches.
- R10: A counter that would pass its maximum value stays at the maximum (all ones).
- R11: If a commit and a matching event reach the same slot in the same cycle, the counter reads zero afterwards.
- R12: A write with bit 63 clear changes no slot: configuration, enable and count all continue as before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| feat_en | input | 1 | Feature enable; register access allowed only when high |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_wdata | input | 64 | Register write data |
| cfg_rdata | output | 64 | Staged register value (zero while feature is disabled) |
| cfg_fault | output | 1 | One-cycle pulse after a refused access |
| evt_valid | input | 1 | Event present this cycle |
| evt_rmid | input | 12 | Event monitoring ID |
| evt_cos | input | 12 | Event class-of-service ID |
| evt_type | input | 32 | Event transaction-type bits |
| evt_bytes | input | BYTES_W | Event byte count |
| rd_id | input | ID_W | Counter slot to read |
| rd_value | output | CNT_W | Value of the selected counter |

## Verification
The bench sends events whose monitoring ID matches but whose type bits do not, events whose type overlaps but whose ID does not, and events that match through the class-of-service ID. These patterns show that both conditions must hold and that each slot uses the ID its select bit names. Events that hit several slots at once show that one event adds to every matching slot. A slot applied with counting off receives the same events and must stay unchanged. A run of large events drives one counter into saturation. A commit placed in the same cycle as a matching event, a staged write without the apply bit, reserved-bit writes and accesses with the feature disabled each test an edge of the apply and fault rules.

// File: rtl/bw_counter_bank.sv
module bw_counter_bank #(
  parameter int SLOTS   = 32,
  parameter int CNT_W   = 48,
  parameter int BYTES_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     feat_en,
  input  logic                     cfg_wr,
  input  logic                     cfg_rd,
  input  logic [63:0]              cfg_wdata,
  output logic [63:0]              cfg_rdata,
  output logic                     cfg_fault,
  input  logic                     evt_valid,
  input  logic [11:0]              evt_rmid,
  input  logic [11:0]              evt_cos,
  input  logic [31:0]              evt_type,
  input  logic [BYTES_W-1:0]       evt_bytes,
  input  logic [$clog2(SLOTS)-1:0] rd_id,
  output logic [CNT_W-1:0]         rd_value
);
  localparam int ID_W = $clog2(SLOTS);
  localparam logic [63:0] RSV_MASK = 64'h3FE0_7000_0000_0000;

  logic [63:0]      stage_q;
  logic [SLOTS-1:0] en_q, cos_q, hit, commit_hit;
  logic [11:0]      src_q  [SLOTS];
  logic [31:0]      type_q [SLOTS];
  logic [CNT_W-1:0] cnt_q  [SLOTS];

  wire       rsv_bad = |(cfg_wdata & RSV_MASK);
  wire       wr_ok   = cfg_wr & feat_en & ~rsv_bad;
  wire       commit  = wr_ok & cfg_wdata[63];
  wire [4:0] cid     = cfg_wdata[52:48];

  assign cfg_rdata = feat_en ? stage_q : 64'd0;
  assign rd_value  = cnt_q[rd_id];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q   <= '0;
      cfg_fault <= 1'b0;
    end else begin
      cfg_fault <= (cfg_wr | cfg_rd) & (~feat_en | (cfg_wr & rsv_bad));
      if (wr_ok) stage_q <= cfg_wdata;
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] sat;
    assign commit_hit[g] = commit && (cid == 5'(g));
    assign hit[g] = evt_valid && en_q[g]
                 && (src_q[g] == (cos_q[g] ? evt_cos : evt_rmid))
                 && |(type_q[g] & evt_type);
    assign sum = {1'b0, cnt_q[g]} + {{(CNT_W + 1 - BYTES_W){1'b0}}, evt_bytes};
    assign sat = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_q[g]   <= 1'b0;
        cos_q[g]  <= 1'b0;
        src_q[g]  <= '0;
        type_q[g] <= '0;
        cnt_q[g]  <= '0;
      end else if (commit_hit[g]) begin
        en_q[g]   <= cfg_wdata[62];
        cos_q[g]  <= cfg_wdata[47];
        src_q[g]  <= cfg_wdata[43:32];
        type_q[g] <= cfg_wdata[31:0];
        cnt_q[g]  <= '0;
      end else if (hit[g]) begin
        cnt_q[g]  <= sat;
      end
    end

    p_commit_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      commit_hit[g] |=> cnt_q[g] == '0);
    p_no_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !commit_hit[g] |=> cnt_q[g] >= $past(cnt_q[g]));
    p_idle_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q[g] && !commit_hit[g]) |=> $stable(cnt_q[g]));
  end

  p_fault_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_wr || cfg_rd) && !feat_en) |=> cfg_fault);
  p_hold_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!feat_en && cfg_wr) |=> $stable(stage_q) && $stable(en_q));
  p_reserved_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && feat_en && rsv_bad) |=> cfg_fault && $stable(stage_q) && $stable(en_q));
  p_stage_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> stage_q == $past(cfg_wdata));
  p_no_apply_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_wdata[63]) |=> $stable(en_q) && $stable(cos_q));
  p_fault_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr && !cfg_rd) |=> !cfg_fault);
endmodule

// File: tb/bw_counter_bank_test.sv
`timescale 1ns/1ps
module bw_counter_bank_test;
  localparam int CW = 12;
  localparam int BW = 8;
  localparam longint CMAX = (64'd1 << CW) - 1;

  logic clk = 0, rst_n = 0, feat_en = 0, cfg_wr = 0, cfg_rd = 0, evt_valid = 0;
  logic [63:0] cfg_wdata = 0, cfg_rdata;
  logic cfg_fault;
  logic [11:0] evt_rmid = 0, evt_cos = 0;
  logic [31:0] evt_type = 0;
  logic [BW-1:0] evt_bytes = 0;
  logic [4:0] rd_id = 0;
  logic [CW-1:0] rd_value;

  int errors = 0, checks = 0;
  string tag = "R1";
  bit started = 0;

  bw_counter_bank #(.SLOTS(32), .CNT_W(CW), .BYTES_W(BW)) uut (.*);

  always #5 clk = ~clk;

  longint m_cnt [32];
  bit     m_en [32], m_cos [32];
  int     m_src [32];
  longint m_type [32];
  longint m_stage;
  bit     m_fault;

  task automatic chk(string t, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", t, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) begin
        m_cnt[i] = 0; m_en[i] = 0; m_cos[i] = 0; m_src[i] = 0; m_type[i] = 0;
      end
      m_stage = 0; m_fault = 0;
    end else begin
      bit rsv, ok;
      rsv = (cfg_wdata[61:53] != 0) || (cfg_wdata[46:44] != 0);
      ok  = cfg_wr && feat_en && !rsv;
      m_fault = (cfg_wr || cfg_rd) && (!feat_en || (cfg_wr && rsv));
      if (evt_valid)
        for (int i = 0; i < 32; i++) begin
          int id;
          id = m_cos[i] ? int'(evt_cos) : int'(evt_rmid);
          if (m_en[i] && id == m_src[i] && ((m_type[i] & longint'(evt_type)) != 0)) begin
            m_cnt[i] += evt_bytes;
            if (m_cnt[i] > CMAX) m_cnt[i] = CMAX;
          end
        end
      if (ok) begin
        m_stage = cfg_wdata;
        if (cfg_wdata[63]) begin
          int s;
          s = int'(cfg_wdata[52:48]);
          m_en[s] = cfg_wdata[62]; m_cos[s] = cfg_wdata[47];
          m_src[s] = int'(cfg_wdata[43:32]); m_type[s] = longint'(cfg_wdata[31:0]);
          m_cnt[s] = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (started) begin
      chk({tag, " fault"}, cfg_fault, m_fault);
      chk({tag, " rdata"}, cfg_rdata, feat_en ? m_stage : 0);
      for (int i = 0; i < 32; i++) begin
        rd_id = 5'(i);
        #0.04;
        chk($sformatf("%s slot%0d", tag, i), rd_value, m_cnt[i]);
      end
    end
  end

  function automatic logic [63:0] mk(bit ap, bit en, int id, bit cos, int src, logic [31:0] ty);
    return {ap, en, 9'd0, 5'(id), cos, 3'd0, 12'(src), ty};
  endfunction

  task automatic cyc(); @(negedge clk); #3; endtask

  task automatic wr(logic [63:0] d);
    cyc(); cfg_wr = 1; cfg_wdata = d;
    cyc(); cfg_wr = 0;
  endtask

  task automatic ev(int rmid, int cos, logic [31:0] ty, int b);
    cyc(); evt_valid = 1; evt_rmid = 12'(rmid); evt_cos = 12'(cos); evt_type = ty; evt_bytes = BW'(b);
    cyc(); evt_valid = 0;
  endtask

  task automatic rd_slot(string t, int s, longint exp);
    @(negedge clk); #2.5; rd_id = 5'(s); #0.1;
    chk(t, rd_value, exp);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #3 rst_n = 1; feat_en = 1;
    cyc(); started = 1;
    tag = "R1"; cyc(); cyc();
    rd_slot("R1 slot5 after reset", 5, 0);
    // R3: access with feature disabled
    tag = "R3"; feat_en = 0;
    wr(mk(1, 1, 3, 0, 18, 32'h5));
    cyc(); cfg_rd = 1; cyc(); cfg_rd = 0; cyc();
    feat_en = 1; cyc();
    chk("R3 rdata still zero", cfg_rdata, 0);
    // R4: reserved bits
    tag = "R4";
    wr(mk(1, 1, 3, 0, 18, 32'h5) | 64'h0020_0000_0000_0000);
    wr(mk(0, 0, 0, 0, 1, 32'h1) | 64'h0000_1000_0000_0000);
    cyc();
    // R2: staged write, no apply
    tag = "R2";
    wr(mk(0, 1, 3, 0, 18, 32'h5));
    cyc(); chk("R2 staged readback", cfg_rdata, mk(0, 1, 3, 0, 18, 32'h5));
    // R5/R7/R6: commits
    tag = "R5";
    wr(mk(1, 1, 3, 0, 18, 32'h5));
    wr(mk(1, 1, 7, 1, 4, 32'h100));
    wr(mk(1, 0, 9, 0, 18, 32'h5));
    wr(mk(1, 1, 11, 0, 18, 32'h4));
    // R8: match patterns
    tag = "R8";
    ev(18, 4, 32'h2, 10);
    ev(19, 18, 32'h1, 11);
    ev(18, 4, 32'h1, 12);
    rd_slot("R8 slot3 after rmid+type match", 3, 12);
    ev(4, 4, 32'h300, 13);
    rd_slot("R8 slot7 via class-of-service", 7, 13);
    tag = "R9";
    ev(18, 0, 32'h4, 20);
    rd_slot("R9 slot3 shared event", 3, 32);
    rd_slot("R9 slot11 shared event", 11, 20);
    tag = "R6";
    rd_slot("R6 slot9 not counting", 9, 0);
    tag = "R7";
    ev(18, 0, 32'h1, 7);
    rd_slot("R7 slot3 keeps counting", 3, 39);
    // R12: write without apply to slot 3
    tag = "R12";
    wr(mk(0, 0, 3, 1, 99, 32'h8));
    ev(18, 0, 32'h1, 5);
    rd_slot("R12 slot3 unchanged config", 3, 44);
    // R11: commit and event same cycle
    tag = "R11";
    cyc(); cfg_wr = 1; cfg_wdata = mk(1, 1, 3, 0, 18, 32'h5);
    evt_valid = 1; evt_rmid = 18; evt_type = 32'h1; evt_bytes = 50;
    cyc(); cfg_wr = 0; evt_valid = 0;
    rd_slot("R11 commit wins", 3, 0);
    // R10: saturation
    tag = "R10";
    for (int k = 0; k < 20; k++) ev(0, 4, 32'h100, 255);
    rd_slot("R10 saturated", 7, CMAX);
    ev(0, 4, 32'h100, 1);
    rd_slot("R10 stays at max", 7, CMAX);
    cyc(); cyc();
    started = 0;
    cyc();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule